// File: doc/BRIEF.md
# Mode-Banked General Register File

This block stores the general registers r0 to r14 of a 32-bit processor that switches between privilege and exception modes. Each access carries the 5-bit mode field of the current status word and a 4-bit register number. A decoder turns the mode into one of six register views and maps the register number onto one flat physical array. Some numbers land on a register that all modes share, and others land on a private copy that belongs to the active exception mode.

There is one write port and two read ports for the general registers. Alongside them sits one saved-status register per exception mode, read and written through a separate port and chosen by the current mode. The block detects a mode value it does not recognise, and a request for a saved-status register in a mode that has none. It raises `err` in both cases, drops the write and drives zero on the affected read data. The program counter lives elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears every general and saved-status register, so every read returns zero after reset.
- R2: In user mode (0x10) and system mode (0x1F), r0 to r14 all address the same 15 shared registers. Both modes see identical contents.
- R3: In fast-interrupt mode (0x11), r0 to r7 address the shared registers and r8 to r14 address seven private registers. Writes in that mode leave the shared r8 to r14 unchanged.
- R4: In interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes, r0 to r12 address the shared registers. r13 and r14 address a pair that is private to each of these modes.
- R5: The only valid mode values are 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F.
- R6: A write is stored on the rising clock edge. Both read ports are combinational and independent, so a read in the write cycle returns the old value.
- R7: Each of the five exception modes has its own saved-status register, accessed through the saved-status port while that mode is active.
- R8: A saved-status read or write in user or system mode raises `err`, reads zero and changes no saved-status register.
- R9: A mode value outside R5 raises `err`, suppresses the general and saved-status writes, and drives zero on every read port.
- R10: Register number 15 reads as zero on both read ports, and a write to it changes no register.
- R11: A general-register write and a saved-status write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Mode field of the current status word |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| sv_wr_en | input | 1 | Saved-status write enable |
| sv_wr_data | input | 32 | Saved-status write data |
| sv_rd_en | input | 1 | Saved-status read request |
| sv_rd_data | output | 32 | Saved-status register of the current mode |
| err | output | 1 | Invalid mode, or saved-status access with no saved register |

## Verification
A general write and a saved-status write can land in the same cycle, and they go to two separate arrays with separate address decode. The bench provokes this in supervisor mode by writing r5 and the saved-status register together. In that same cycle it reads both back and expects the old values. In the next cycle it reads both again and expects both new values. The scoreboard model keeps the shared, fast-interrupt, paired and saved-status stores as separate arrays, so a write routed through the wrong decode shows up as a mismatch on a later read.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;
  localparam int NUM_SHARED = 15;
  localparam int FIQ_FIRST  = 8;
  localparam int FIQ_CNT    = NUM_SHARED - FIQ_FIRST;
  localparam int PAIR_FIRST = 13;
  localparam int PAIR_CNT   = NUM_SHARED - PAIR_FIRST;
  localparam int PAIR_MODES = 4;
  localparam int FIQ_BASE   = NUM_SHARED;
  localparam int PAIR_BASE  = FIQ_BASE + FIQ_CNT;
  localparam int NUM_PHYS   = PAIR_BASE + PAIR_CNT * PAIR_MODES;
  localparam int NUM_SAVED  = PAIR_MODES + 1;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int SAV_W      = $clog2(NUM_SAVED);
  localparam int IDX_W      = 4;

  localparam logic [4:0] MD_USR = 5'h10;
  localparam logic [4:0] MD_FIQ = 5'h11;
  localparam logic [4:0] MD_IRQ = 5'h12;
  localparam logic [4:0] MD_SVC = 5'h13;
  localparam logic [4:0] MD_ABT = 5'h17;
  localparam logic [4:0] MD_UND = 5'h1B;
  localparam logic [4:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    VW_USR = 3'd0, VW_FIQ = 3'd1, VW_IRQ = 3'd2, VW_SVC = 3'd3,
    VW_ABT = 3'd4, VW_UND = 3'd5, VW_BAD = 3'd6
  } view_t;

  function automatic view_t view_of(logic [4:0] md);
    case (md)
      MD_USR, MD_SYS: return VW_USR;
      MD_FIQ:         return VW_FIQ;
      MD_IRQ:         return VW_IRQ;
      MD_SVC:         return VW_SVC;
      MD_ABT:         return VW_ABT;
      MD_UND:         return VW_UND;
      default:        return VW_BAD;
    endcase
  endfunction

  function automatic logic is_pair_view(view_t v);
    return (v == VW_IRQ) || (v == VW_SVC) || (v == VW_ABT) || (v == VW_UND);
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(view_t v, logic [IDX_W-1:0] idx);
    int n;
    n = int'(idx);
    if (v == VW_FIQ && n >= FIQ_FIRST)
      n = FIQ_BASE + n - FIQ_FIRST;
    else if (is_pair_view(v) && n >= PAIR_FIRST)
      n = PAIR_BASE + (int'(v) - int'(VW_IRQ)) * PAIR_CNT + n - PAIR_FIRST;
    return PHYS_W'(n);
  endfunction

  function automatic logic [SAV_W-1:0] saved_of(view_t v);
    return SAV_W'(int'(v) - int'(VW_FIQ));
  endfunction
endpackage

// File: rtl/bank_mode_decode.sv
`timescale 1ns/1ps
module bank_mode_decode
  import bankreg_pkg::*;
(
  input  logic [4:0]       mode_i,
  output view_t            view_o,
  output logic             mode_ok_o,
  output logic             has_saved_o,
  output logic [SAV_W-1:0] sav_sel_o
);
  always_comb begin
    view_o      = view_of(mode_i);
    mode_ok_o   = (view_o != VW_BAD);
    has_saved_o = (view_o == VW_FIQ) || is_pair_view(view_o);
    sav_sel_o   = has_saved_o ? saved_of(view_o) : '0;
  end
endmodule

// File: rtl/bank_map.sv
`timescale 1ns/1ps
module bank_map
  import bankreg_pkg::*;
(
  input  view_t             view_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              ok_o
);
  always_comb begin
    ok_o   = (view_i != VW_BAD) && (int'(idx_i) < NUM_SHARED);
    phys_o = ok_o ? phys_of(view_i, idx_i) : '0;
  end
endmodule

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store
  import bankreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gpr_we,
  input  logic [PHYS_W-1:0] gpr_wa,
  input  logic [DW-1:0]     gpr_wd,
  input  logic [PHYS_W-1:0] gpr_ra0,
  input  logic [PHYS_W-1:0] gpr_ra1,
  output logic [DW-1:0]     gpr_rd0,
  output logic [DW-1:0]     gpr_rd1,
  input  logic              sav_we,
  input  logic [SAV_W-1:0]  sav_sel,
  input  logic [DW-1:0]     sav_wd,
  output logic [DW-1:0]     sav_rd
);
  logic [DW-1:0] gpr [NUM_PHYS];
  logic [DW-1:0] sav [NUM_SAVED];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++) gpr[i] <= '0;
      for (int j = 0; j < NUM_SAVED; j++) sav[j] <= '0;
    end else begin
      if (gpr_we) gpr[gpr_wa] <= gpr_wd;
      if (sav_we) sav[sav_sel] <= sav_wd;
    end
  end

  assign gpr_rd0 = gpr[gpr_ra0];
  assign gpr_rd1 = gpr[gpr_ra1];
  assign sav_rd  = sav[sav_sel];
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode_i,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          sv_wr_en,
  input  logic [DW-1:0] sv_wr_data,
  input  logic          sv_rd_en,
  output logic [DW-1:0] sv_rd_data,
  output logic          err
);
  localparam int NPORT = 3;  // 0: write, 1: read A, 2: read B

  view_t             view;
  logic              mode_ok, has_saved;
  logic [SAV_W-1:0]  sav_sel;
  logic [IDX_W-1:0]  port_idx  [NPORT];
  logic [PHYS_W-1:0] port_phys [NPORT];
  logic              port_ok   [NPORT];
  logic [DW-1:0]     raw_a, raw_b, raw_sv;

  // named events for the checker
  logic mode_bad, sv_fault, wr_fire, sv_wr_fire;

  bank_mode_decode u_dec (
    .mode_i(mode_i), .view_o(view), .mode_ok_o(mode_ok),
    .has_saved_o(has_saved), .sav_sel_o(sav_sel)
  );

  assign port_idx[0] = wr_idx;
  assign port_idx[1] = rd_a_idx;
  assign port_idx[2] = rd_b_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bank_map u_map (
      .view_i(view), .idx_i(port_idx[p]),
      .phys_o(port_phys[p]), .ok_o(port_ok[p])
    );
  end

  assign mode_bad   = !mode_ok;
  assign sv_fault   = !has_saved && (sv_rd_en || sv_wr_en);
  assign wr_fire    = wr_en && port_ok[0];
  assign sv_wr_fire = sv_wr_en && has_saved;

  bank_store #(.DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .gpr_we(wr_fire), .gpr_wa(port_phys[0]), .gpr_wd(wr_data),
    .gpr_ra0(port_phys[1]), .gpr_ra1(port_phys[2]),
    .gpr_rd0(raw_a), .gpr_rd1(raw_b),
    .sav_we(sv_wr_fire), .sav_sel(sav_sel), .sav_wd(sv_wr_data),
    .sav_rd(raw_sv)
  );

  assign rd_a_data  = port_ok[1] ? raw_a  : '0;
  assign rd_b_data  = port_ok[2] ? raw_b  : '0;
  assign sv_rd_data = has_saved  ? raw_sv : '0;
  assign err        = mode_bad || sv_fault;
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    mode_i,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          sv_wr_en,
  input logic          sv_rd_en,
  input logic [DW-1:0] sv_rd_data,
  input logic          err,
  input logic          wr_fire
);
  logic known_mode, saved_mode;
  always_comb begin
    known_mode = (mode_i == 5'h10) || (mode_i == 5'h11) || (mode_i == 5'h12) ||
                 (mode_i == 5'h13) || (mode_i == 5'h17) || (mode_i == 5'h1B) ||
                 (mode_i == 5'h1F);
    saved_mode = known_mode && (mode_i != 5'h10) && (mode_i != 5'h1F);
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0 && sv_rd_data == '0)); // R1

  AST_BAD_MODE_ERR: assert property (@(posedge clk) disable iff (rst)
    !known_mode |-> (err && rd_a_data == '0 && rd_b_data == '0 && sv_rd_data == '0)); // R9

  AST_SAVED_NONE_ERR: assert property (@(posedge clk) disable iff (rst)
    (!saved_mode && (sv_rd_en || sv_wr_en)) |-> (err && sv_rd_data == '0)); // R8

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data)); // R6

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_fire) && !$past(rst) && mode_i == $past(mode_i) && rd_a_idx == $past(wr_idx))
      |-> (rd_a_data == $past(wr_data))); // R6

  AST_IDX15_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 4'd15) |-> (rd_a_data == '0)); // R10
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
  .rd_b_data(rd_b_data), .sv_wr_en(sv_wr_en), .sv_rd_en(sv_rd_en),
  .sv_rd_data(sv_rd_data), .err(err), .wr_fire(wr_fire)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  localparam int DW = 32;
  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                         M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, wr_en, sv_wr_en, sv_rd_en, err;
  logic [4:0] mode_i;
  logic [3:0] wr_idx, rd_a_idx, rd_b_idx;
  logic [DW-1:0] wr_data, sv_wr_data, rd_a_data, rd_b_data, sv_rd_data;

  banked_regfile #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .sv_wr_en(sv_wr_en),
    .sv_wr_data(sv_wr_data), .sv_rd_en(sv_rd_en), .sv_rd_data(sv_rd_data), .err(err)
  );

  // ---------------- reference model ----------------
  logic [DW-1:0] m_usr [15];
  logic [DW-1:0] m_fiq [7];
  logic [DW-1:0] m_pair [4][2];
  logic [DW-1:0] m_sav [5];

  function automatic int vcode(logic [4:0] m);
    if (m == M_USR || m == M_SYS) return 0;
    if (m == M_FIQ) return 1;
    if (m == M_IRQ) return 2;
    if (m == M_SVC) return 3;
    if (m == M_ABT) return 4;
    if (m == M_UND) return 5;
    return -1;
  endfunction

  function automatic logic [DW-1:0] m_read(logic [4:0] m, logic [3:0] i);
    int v = vcode(m);
    int n = int'(i);
    if (v < 0 || n == 15) return '0;
    if (v == 1 && n >= 8) return m_fiq[n-8];
    if (v >= 2 && n >= 13) return m_pair[v-2][n-13];
    return m_usr[n];
  endfunction

  task automatic m_write(logic [4:0] m, logic [3:0] i, logic [DW-1:0] d);
    int v = vcode(m);
    int n = int'(i);
    if (v < 0 || n == 15) return;
    if (v == 1 && n >= 8) m_fiq[n-8] = d;
    else if (v >= 2 && n >= 13) m_pair[v-2][n-13] = d;
    else m_usr[n] = d;
  endtask

  function automatic logic [DW-1:0] m_sv_read(logic [4:0] m);
    int v = vcode(m);
    return (v >= 1) ? m_sav[v-1] : '0;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++) m_fiq[i] = '0;
    for (int i = 0; i < 4; i++) begin m_pair[i][0] = '0; m_pair[i][1] = '0; end
    for (int i = 0; i < 5; i++) m_sav[i] = '0;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    int            kind;   // 0 port A, 1 port B, 2 saved, 3 err
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sbq[$];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic push(int k, logic [DW-1:0] e, string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    item_t it;
    logic [DW-1:0] act;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        0: act = rd_a_data;
        1: act = rd_b_data;
        2: act = sv_rd_data;
        default: act = {{(DW-1){1'b0}}, err};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d actual=%h expected=%h t=%0t", it.tag, it.kind, act, it.exp, $time);
      end
    end
  end

  // driver: called just after a rising edge; queues expectations from the
  // pre-edge model state, then lets the edge commit writes
  task automatic step(logic [4:0] m, logic we, logic [3:0] wi, logic [DW-1:0] wd,
                      logic swe, logic [DW-1:0] swd, logic [3:0] ra, logic [3:0] rb,
                      logic sre, string tag);
    int v;
    mode_i = m; wr_en = we; wr_idx = wi; wr_data = wd;
    sv_wr_en = swe; sv_wr_data = swd; sv_rd_en = sre;
    rd_a_idx = ra; rd_b_idx = rb;
    v = vcode(m);
    push(0, m_read(m, ra), tag);
    push(1, m_read(m, rb), tag);
    push(2, m_sv_read(m), tag);
    push(3, DW'((v < 0) || ((swe || sre) && v == 0)), tag);
    @(posedge clk);
    if (we) m_write(m, wi, wd);
    if (swe && v >= 1) m_sav[v-1] = swd;
    #1;
    wr_en = 1'b0; sv_wr_en = 1'b0; sv_rd_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] m, logic [3:0] ra, logic [3:0] rb, string tag);
    step(m, 1'b0, 4'd0, '0, 1'b0, '0, ra, rb, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    m_clear();
    #1 rst = 1'b0;
  endtask

  function automatic string name_r(int k);
    return $sformatf("R%0d", k);
  endfunction

  logic [4:0] pm [4];

  initial begin
    pm[0] = M_IRQ; pm[1] = M_SVC; pm[2] = M_ABT; pm[3] = M_UND;
    rst = 1'b1; mode_i = M_USR; wr_en = 0; wr_idx = 0; wr_data = '0;
    sv_wr_en = 0; sv_wr_data = '0; sv_rd_en = 0; rd_a_idx = 0; rd_b_idx = 0;
    do_reset();

    // R1: reset state
    rd(M_USR, 4'd0, 4'd14, "R1");
    step(M_SVC, 0, 0, '0, 0, '0, 4'd13, 4'd14, 1, "R1");
    rd(M_FIQ, 4'd8, 4'd12, "R1");

    // R2 / R6: fill shared registers in user mode; same-cycle read sees old value
    for (int i = 0; i < 15; i++)
      step(M_USR, 1, 4'(i), 32'h1000 + i, 0, '0, 4'(i), 4'(14 - i), 0, "R6");
    for (int i = 0; i < 15; i++) rd(M_SYS, 4'(i), 4'(14 - i), "R2");
    step(M_SYS, 1, 4'd3, 32'h1F03, 0, '0, 4'd3, 4'd3, 0, "R2");
    rd(M_USR, 4'd3, 4'd4, "R2");

    // R3: fast-interrupt bank
    for (int i = 8; i < 15; i++)
      step(M_FIQ, 1, 4'(i), 32'h2000 + i, 0, '0, 4'(i), 4'd0, 0, "R3");
    for (int i = 0; i < 15; i++) rd(M_FIQ, 4'(i), 4'(i), "R3");
    for (int i = 8; i < 15; i++) rd(M_USR, 4'(i), 4'(i - 8), "R3");

    // R4 / R5: paired banks
    for (int k = 0; k < 4; k++) begin
      step(pm[k], 1, 4'd13, 32'h3000 + 16 * k + 13, 0, '0, 4'd13, 4'd12, 0, "R4");
      step(pm[k], 1, 4'd14, 32'h3000 + 16 * k + 14, 0, '0, 4'd14, 4'd12, 0, "R4");
    end
    for (int k = 0; k < 4; k++) begin
      rd(pm[k], 4'd13, 4'd14, "R4");
      rd(pm[k], 4'd12, 4'd8, "R5");
    end
    rd(M_USR, 4'd13, 4'd14, "R4");

    // R7: saved-status per exception mode
    step(M_FIQ, 0, 0, '0, 1, 32'h5000, 4'd0, 4'd1, 1, "R7");
    for (int k = 0; k < 4; k++)
      step(pm[k], 0, 0, '0, 1, 32'h5001 + k, 4'd0, 4'd1, 1, "R7");
    rd(M_FIQ, 4'd9, 4'd2, "R7");
    for (int k = 0; k < 4; k++)
      step(pm[k], 0, 0, '0, 0, '0, 4'd13, 4'd1, 1, "R7");

    // R8: saved-status in user/system
    step(M_USR, 0, 0, '0, 1, 32'hDEAD_0001, 4'd0, 4'd1, 1, "R8");
    step(M_SYS, 0, 0, '0, 1, 32'hDEAD_0002, 4'd0, 4'd1, 0, "R8");
    step(M_SVC, 0, 0, '0, 0, '0, 4'd0, 4'd1, 1, "R8");
    step(M_FIQ, 0, 0, '0, 0, '0, 4'd0, 4'd1, 1, "R8");

    // R9: unknown modes
    step(5'h00, 1, 4'd0, 32'hBAD0, 1, 32'hBAD1, 4'd0, 4'd14, 1, "R9");
    step(5'h14, 1, 4'd13, 32'hBAD2, 0, '0, 4'd13, 4'd1, 0, "R9");
    step(5'h1E, 1, 4'd8, 32'hBAD3, 1, 32'hBAD4, 4'd8, 4'd8, 1, "R9");
    rd(M_USR, 4'd0, 4'd13, "R9");
    step(M_UND, 0, 0, '0, 0, '0, 4'd13, 4'd8, 1, "R9");
    rd(M_FIQ, 4'd8, 4'd0, "R9");

    // R10: register number 15
    step(M_USR, 1, 4'd15, 32'hF15F, 0, '0, 4'd15, 4'd15, 0, "R10");
    rd(M_FIQ, 4'd8, 4'd15, "R10");
    rd(M_USR, 4'd15, 4'd14, "R10");

    // R11: general and saved-status writes together
    step(M_SVC, 1, 4'd5, 32'h7777, 1, 32'h8888, 4'd5, 4'd14, 1, "R11");
    step(M_SVC, 0, 0, '0, 0, '0, 4'd5, 4'd13, 1, "R11");
    step(M_ABT, 1, 4'd14, 32'h9999, 1, 32'hAAAA, 4'd14, 4'd5, 1, "R11");
    step(M_ABT, 0, 0, '0, 0, '0, 4'd14, 4'd5, 1, "R11");

    // R1: reset during operation
    do_reset();
    rd(M_USR, 4'd5, 4'd3, "R1");
    step(M_ABT, 0, 0, '0, 0, '0, 4'd14, 4'd13, 1, "R1");
    rd(M_FIQ, 4'd10, 4'd14, "R1");

    @(posedge clk); #1;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule